// File: doc/BRIEF.md
# Cipher Control Packet Parser

This block sits behind a descriptor-driven DMA engine on the transmit side of a crypto accelerator. Every descriptor the DMA engine fetches comes with a 10-bit operation flag. When the control bit of that flag is set, the buffer the descriptor points at holds a control packet. The DMA engine then streams that buffer into the parser as 32-bit words. The flag, not the packet itself, decides which words are present. The header word always comes first. After it may come a length word, then the initialisation-vector words, then up to three groups of key words. The parser maps each arriving word onto its slot and latches the fields a cipher datapath needs into one operation record.

A descriptor whose control bit is clear is a plain data descriptor. The parser accepts such a descriptor and consumes none of its words. Once the buffer ends, the parser checks the header. A legal packet is presented as a record with a valid/ready handshake, and the record is held until it is taken. An illegal header raises a one-cycle protocol-error pulse, and so does a buffer that ends too early; in both cases no record is presented. Words that follow the last required one are dropped until the end of the buffer.

Top module: `ccp_parser`

## Requirements
- R1: After reset `rec_valid`, `proto_err` and `in_ready` are 0 and `desc_ready` is 1.
- R2: An accepted descriptor whose flag bit 0 is clear yields no record and no error. No word is consumed (`in_ready` stays 0) and `desc_ready` stays 1.
- R3: Words arrive in this order: header; then a length word if flag bit 1 is set; then IV_WORDS IV words if bit 3 is set; then key words 0..3 if bit 4 is set, key words 4..5 if bit 5 is set, and key words 6..7 if bit 6 is set. Key word n appears at `rec_key[255-32n -: 32]` and IV word m at `rec_iv[32*IV_WORDS-1-32m -: 32]`. Key and IV words that are not present read zero.
- R4: The header fields are decoded as follows: process id [7:0], AES key word count [23:20], cipher algorithm [26:24] and operation mode [31:28]. `rec_decrypt` is 1 for mode 3 and 0 for mode 1. The algorithm code is passed through unchanged (code 2 selects AES in ECB mode). Bits [19:8] and [27] are ignored.
- R5: The length word supplies `rec_payload_len` from its bits [15:0] and `rec_hdr_len` from its bits [31:16]. Both fields are zero when flag bit 1 is clear.
- R6: Flag bits 2, 7, 8 and 9 (the authentication flags) do not change which words are expected.
- R7: A mode other than 1 or 3, or a key word count other than 4, 6 or 8, raises `proto_err` for exactly one cycle. No record is presented in that case.
- R8: If `in_last` arrives before the last word the flag requires, `proto_err` pulses for one cycle, no record is presented, and the parser returns to waiting for a descriptor.
- R9: Words after the last required word are accepted and discarded until `in_last`. They change no record field.
- R10: While `rec_valid` is high and `rec_ready` is low, the record stays stable and `in_ready` and `desc_ready` stay low. After a cycle with `rec_ready` high, `rec_valid` is low and `desc_ready` is high.
- R11: `rec_valid` (or `proto_err` for a bad header) is visible two clock edges after the edge that takes the final buffer word. `proto_err` for a short buffer is visible one edge after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Descriptor flag offered |
| desc_flag | input | 10 | Per-descriptor operation flag bitmap |
| desc_ready | output | 1 | Parser can take a descriptor |
| in_valid | input | 1 | Control word offered |
| in_data | input | 32 | Control word |
| in_last | input | 1 | Final word of the control buffer |
| in_ready | output | 1 | Parser takes control words |
| rec_valid | output | 1 | Operation record available |
| rec_ready | input | 1 | Consumer takes the record |
| rec_decrypt | output | 1 | 1 = decrypt, 0 = encrypt |
| rec_algo | output | 3 | Cipher algorithm code |
| rec_key_words | output | 4 | AES key length in 32-bit words |
| rec_proc_id | output | 8 | Process identifier |
| rec_payload_len | output | 16 | Cipher payload length |
| rec_hdr_len | output | 16 | Header length |
| rec_iv | output | 32*IV_WORDS | Initialisation vector, word 0 most significant |
| rec_key | output | 256 | Key, word 0 most significant |
| proto_err | output | 1 | One-cycle malformed-packet pulse |

## Verification
The full 128/192/256-bit flag set is tried against flags that leave out the length word, add IV words, carry only the top key group, or carry only a header. Comparing these shows that each word is mapped to its slot by the flag and not by its position alone. A flag with the authentication bits added is compared with the same packet without them. Illegal mode and key-count headers are set against a truncated buffer, which tells apart the late error from the early one. A buffer with trailing words tells draining apart from overwriting. A data-only descriptor shows that no words are consumed. Each record is then held against a stalled consumer before it is released.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

    localparam int WORD_W    = 32;
    localparam int KEY_WORDS = 8;
    localparam int FLAG_W    = 10;

    // flag bit positions that change the word layout
    localparam int F_CTRL = 0;
    localparam int F_LEN  = 1;
    localparam int F_IV   = 3;
    localparam int F_K0   = 4;
    localparam int F_K4   = 5;
    localparam int F_K6   = 6;

    localparam logic [3:0] MODE_ENC = 4'd1;
    localparam logic [3:0] MODE_DEC = 4'd3;

    typedef enum logic [1:0] {
        SLOT_HDR,
        SLOT_LEN,
        SLOT_IV,
        SLOT_KEY
    } slot_e;

    typedef struct packed {
        slot_e      kind;
        logic [3:0] sub;
    } slot_t;

    typedef struct packed {
        logic       decrypt;
        logic [2:0] algo;
        logic [3:0] key_words;
        logic [7:0] proc_id;
        logic       legal;
    } hdr_info_t;

    // number of words the flag requires in the control buffer
    function automatic logic [7:0] expected_words(logic [FLAG_W-1:0] f, logic [7:0] ivw);
        logic [7:0] n;
        n = 8'd1;
        if (f[F_LEN]) n = n + 8'd1;
        if (f[F_IV])  n = n + ivw;
        if (f[F_K0])  n = n + 8'd4;
        if (f[F_K4])  n = n + 8'd2;
        if (f[F_K6])  n = n + 8'd2;
        return n;
    endfunction

    // slot of the word at position idx in the buffer
    function automatic slot_t word_slot(logic [FLAG_W-1:0] f, logic [7:0] idx, logic [7:0] ivw);
        slot_t      s;
        logic [7:0] k;
        s.kind = SLOT_HDR;
        s.sub  = 4'd0;
        k      = idx;
        if (k == 8'd0) return s;
        k = k - 8'd1;
        if (f[F_LEN]) begin
            if (k == 8'd0) begin
                s.kind = SLOT_LEN;
                return s;
            end
            k = k - 8'd1;
        end
        if (f[F_IV]) begin
            if (k < ivw) begin
                s.kind = SLOT_IV;
                s.sub  = k[3:0];
                return s;
            end
            k = k - ivw;
        end
        s.kind = SLOT_KEY;
        if (f[F_K0]) begin
            if (k < 8'd4) begin
                s.sub = k[3:0];
                return s;
            end
            k = k - 8'd4;
        end
        if (f[F_K4]) begin
            if (k < 8'd2) begin
                s.sub = 4'd4 + k[3:0];
                return s;
            end
            k = k - 8'd2;
        end
        s.sub = 4'd6 + k[3:0];
        return s;
    endfunction

endpackage

// File: rtl/ccp_header_decode.sv
module ccp_header_decode
    import ccp_pkg::*;
(
    input  logic [3:0] mode,
    input  logic [3:0] nk,
    input  logic [2:0] alg,
    input  logic [7:0] pid,
    output hdr_info_t  info
);
    logic mode_ok;
    logic nk_ok;

    always_comb begin
        mode_ok        = (mode == MODE_ENC) || (mode == MODE_DEC);
        nk_ok          = (nk == 4'd4) || (nk == 4'd6) || (nk == 4'd8);
        info.decrypt   = (mode == MODE_DEC);
        info.algo      = alg;
        info.key_words = nk;
        info.proc_id   = pid;
        info.legal     = mode_ok && nk_ok;
    end
endmodule

// File: rtl/ccp_record_latch.sv
module ccp_record_latch
    import ccp_pkg::*;
#(
    parameter int IV_WORDS = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clear,
    input  logic                         wr_en,
    input  slot_t                        wr_slot,
    input  logic [WORD_W-1:0]            wr_data,
    input  hdr_info_t                    hdr_in,
    output hdr_info_t                    hdr_q,
    output logic [WORD_W-1:0]            len_q,
    output logic [WORD_W*IV_WORDS-1:0]   iv_q,
    output logic [WORD_W*KEY_WORDS-1:0]  key_q
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            hdr_q <= '0;
            len_q <= '0;
        end else if (wr_en) begin
            if (wr_slot.kind == SLOT_HDR) hdr_q <= hdr_in;
            if (wr_slot.kind == SLOT_LEN) len_q <= wr_data;
        end
    end

    for (genvar g = 0; g < KEY_WORDS; g++) begin : g_key
        logic [WORD_W-1:0] kw;
        always_ff @(posedge clk) begin
            if (rst || clear)
                kw <= '0;
            else if (wr_en && wr_slot.kind == SLOT_KEY && wr_slot.sub == 4'(g))
                kw <= wr_data;
        end
        assign key_q[WORD_W*(KEY_WORDS-g)-1 -: WORD_W] = kw;
    end

    for (genvar g = 0; g < IV_WORDS; g++) begin : g_iv
        logic [WORD_W-1:0] vw;
        always_ff @(posedge clk) begin
            if (rst || clear)
                vw <= '0;
            else if (wr_en && wr_slot.kind == SLOT_IV && wr_slot.sub == 4'(g))
                vw <= wr_data;
        end
        assign iv_q[WORD_W*(IV_WORDS-g)-1 -: WORD_W] = vw;
    end
endmodule

// File: rtl/ccp_sequencer.sv
module ccp_sequencer
    import ccp_pkg::*;
#(
    parameter int IV_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              desc_valid,
    input  logic [FLAG_W-1:0] desc_flag,
    output logic              desc_ready,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    input  logic              hdr_ok,
    input  logic              rec_ready,
    output logic              rec_valid,
    output logic              proto_err,
    output logic              start,
    output logic              wr_en,
    output slot_t             wr_slot
);
    localparam int MAX_WORDS = 2 + IV_WORDS + KEY_WORDS;
    localparam int CNT_W     = $clog2(MAX_WORDS + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PARSE,
        ST_DRAIN,
        ST_CHECK,
        ST_HOLD
    } state_e;

    state_e            state;
    logic [FLAG_W-1:0] flag_q;
    logic [CNT_W-1:0]  idx_q;
    logic [CNT_W-1:0]  total_q;
    logic              err_q;
    logic              is_final;

    always_comb begin
        desc_ready = (state == ST_IDLE);
        in_ready   = (state == ST_PARSE) || (state == ST_DRAIN);
        rec_valid  = (state == ST_HOLD);
        proto_err  = err_q;
        start      = desc_valid && desc_ready && desc_flag[F_CTRL];
        wr_en      = (state == ST_PARSE) && in_valid;
        wr_slot    = word_slot(flag_q, 8'(idx_q), 8'(IV_WORDS));
        is_final   = (idx_q == total_q - CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            flag_q  <= '0;
            idx_q   <= '0;
            total_q <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        flag_q  <= desc_flag;
                        total_q <= CNT_W'(expected_words(desc_flag, 8'(IV_WORDS)));
                        idx_q   <= '0;
                        state   <= ST_PARSE;
                    end
                end
                ST_PARSE: begin
                    if (in_valid) begin
                        idx_q <= idx_q + CNT_W'(1);
                        if (is_final) begin
                            state <= in_last ? ST_CHECK : ST_DRAIN;
                        end else if (in_last) begin
                            err_q <= 1'b1;
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (in_valid && in_last) state <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (hdr_ok) begin
                        state <= ST_HOLD;
                    end else begin
                        err_q <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                ST_HOLD: begin
                    if (rec_ready) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ccp_parser.sv
module ccp_parser
    import ccp_pkg::*;
#(
    parameter int IV_WORDS = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           desc_valid,
    input  logic [9:0]                     desc_flag,
    output logic                           desc_ready,
    input  logic                           in_valid,
    input  logic [31:0]                    in_data,
    input  logic                           in_last,
    output logic                           in_ready,
    output logic                           rec_valid,
    input  logic                           rec_ready,
    output logic                           rec_decrypt,
    output logic [2:0]                     rec_algo,
    output logic [3:0]                     rec_key_words,
    output logic [7:0]                     rec_proc_id,
    output logic [15:0]                    rec_payload_len,
    output logic [15:0]                    rec_hdr_len,
    output logic [32*IV_WORDS-1:0]         rec_iv,
    output logic [255:0]                   rec_key,
    output logic                           proto_err
);
    logic        start;
    logic        wr_en;
    slot_t       wr_slot;
    hdr_info_t   hdr_new;
    hdr_info_t   hdr_q;
    logic [31:0] len_q;

    ccp_sequencer #(.IV_WORDS(IV_WORDS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .desc_valid (desc_valid),
        .desc_flag  (desc_flag),
        .desc_ready (desc_ready),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .in_ready   (in_ready),
        .hdr_ok     (hdr_q.legal),
        .rec_ready  (rec_ready),
        .rec_valid  (rec_valid),
        .proto_err  (proto_err),
        .start      (start),
        .wr_en      (wr_en),
        .wr_slot    (wr_slot)
    );

    ccp_header_decode u_dec (
        .mode (in_data[31:28]),
        .nk   (in_data[23:20]),
        .alg  (in_data[26:24]),
        .pid  (in_data[7:0]),
        .info (hdr_new)
    );

    ccp_record_latch #(.IV_WORDS(IV_WORDS)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .clear   (start),
        .wr_en   (wr_en),
        .wr_slot (wr_slot),
        .wr_data (in_data),
        .hdr_in  (hdr_new),
        .hdr_q   (hdr_q),
        .len_q   (len_q),
        .iv_q    (rec_iv),
        .key_q   (rec_key)
    );

    assign rec_decrypt     = hdr_q.decrypt;
    assign rec_algo        = hdr_q.algo;
    assign rec_key_words   = hdr_q.key_words;
    assign rec_proc_id     = hdr_q.proc_id;
    assign rec_payload_len = len_q[15:0];
    assign rec_hdr_len     = len_q[31:16];
endmodule

// File: rtl/ccp_parser_checks.sv
module ccp_parser_checks (
    input logic         clk,
    input logic         rst,
    input logic         desc_ready,
    input logic         in_ready,
    input logic         rec_valid,
    input logic         rec_ready,
    input logic [3:0]   rec_key_words,
    input logic [255:0] rec_key,
    input logic [15:0]  rec_payload_len,
    input logic         proto_err
);
    p_hold_stable_r10: assert property (@(posedge clk) disable iff (rst)
        rec_valid && !rec_ready |=> rec_valid && $stable(rec_key) && $stable(rec_payload_len));

    p_no_intake_in_hold_r10: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> !in_ready && !desc_ready);

    p_legal_record_r7: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> (rec_key_words == 4'd4 || rec_key_words == 4'd6 || rec_key_words == 4'd8));

    p_err_no_record_r7: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> !rec_valid);

    p_err_single_r8: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> !proto_err);

    p_idle_takes_no_words_r2: assert property (@(posedge clk) disable iff (rst)
        desc_ready |-> !in_ready);

    p_record_after_check_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(rec_valid) |-> $past(!in_ready && !desc_ready));
endmodule

bind ccp_parser ccp_parser_checks u_chk (
    .clk             (clk),
    .rst             (rst),
    .desc_ready      (desc_ready),
    .in_ready        (in_ready),
    .rec_valid       (rec_valid),
    .rec_ready       (rec_ready),
    .rec_key_words   (rec_key_words),
    .rec_key         (rec_key),
    .rec_payload_len (rec_payload_len),
    .proto_err       (proto_err)
);

// File: tb/ccp_parser_test.sv
module ccp_parser_test;
    localparam int IVW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic              desc_valid = 1'b0;
    logic [9:0]        desc_flag  = '0;
    logic              desc_ready;
    logic              in_valid   = 1'b0;
    logic [31:0]       in_data    = '0;
    logic              in_last    = 1'b0;
    logic              in_ready;
    logic              rec_valid;
    logic              rec_ready  = 1'b0;
    logic              rec_decrypt;
    logic [2:0]        rec_algo;
    logic [3:0]        rec_key_words;
    logic [7:0]        rec_proc_id;
    logic [15:0]       rec_payload_len;
    logic [15:0]       rec_hdr_len;
    logic [32*IVW-1:0] rec_iv;
    logic [255:0]      rec_key;
    logic              proto_err;

    ccp_parser #(.IV_WORDS(IVW)) uut (
        .clk (clk), .rst (rst),
        .desc_valid (desc_valid), .desc_flag (desc_flag), .desc_ready (desc_ready),
        .in_valid (in_valid), .in_data (in_data), .in_last (in_last), .in_ready (in_ready),
        .rec_valid (rec_valid), .rec_ready (rec_ready),
        .rec_decrypt (rec_decrypt), .rec_algo (rec_algo), .rec_key_words (rec_key_words),
        .rec_proc_id (rec_proc_id), .rec_payload_len (rec_payload_len),
        .rec_hdr_len (rec_hdr_len), .rec_iv (rec_iv), .rec_key (rec_key),
        .proto_err (proto_err)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mkhdr(logic [3:0] mode, logic [2:0] alg, logic [3:0] nk,
                                          logic [11:0] mid, logic [7:0] pid);
        return {mode, 1'b0, alg, nk, mid, pid};
    endfunction

    // outcome: 0 record, 1 bad header (late error), 2 short buffer (early error)
    typedef struct packed {
        logic [9:0]  flag;
        logic [31:0] hdr;
        logic [31:0] lenw;
        logic [3:0]  extra;
        logic [3:0]  cut;
        logic [1:0]  outcome;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{10'h073, mkhdr(4'd1, 3'd2, 4'd8, 12'h000, 8'h11), 32'h0000_0040, 4'd0, 4'd0, 2'd0}, // R3 R4 R5
        '{10'h013, mkhdr(4'd3, 3'd2, 4'd4, 12'h000, 8'h22), 32'h0000_0030, 4'd0, 4'd0, 2'd0}, // R4 decrypt
        '{10'h07B, mkhdr(4'd1, 3'd2, 4'd6, 12'h000, 8'h33), 32'h0010_0020, 4'd0, 4'd0, 2'd0}, // R3 IV
        '{10'h031, mkhdr(4'd3, 3'd2, 4'd6, 12'h000, 8'h44), 32'hFFFF_FFFF, 4'd0, 4'd0, 2'd0}, // R5 no len
        '{10'h3F7, mkhdr(4'd1, 3'd2, 4'd8, 12'h5A5, 8'h55), 32'h0000_0040, 4'd0, 4'd0, 2'd0}, // R6 auth bits
        '{10'h073, mkhdr(4'd2, 3'd2, 4'd8, 12'h000, 8'h66), 32'h0000_0040, 4'd0, 4'd0, 2'd1}, // R7 mode
        '{10'h073, mkhdr(4'd1, 3'd2, 4'd5, 12'h000, 8'h77), 32'h0000_0040, 4'd0, 4'd0, 2'd1}, // R7 key count
        '{10'h073, mkhdr(4'd1, 3'd2, 4'd8, 12'h000, 8'h88), 32'h0000_0040, 4'd0, 4'd3, 2'd2}, // R8 short
        '{10'h013, mkhdr(4'd1, 3'd2, 4'd4, 12'h000, 8'h99), 32'h0002_0010, 4'd3, 4'd0, 2'd0}, // R9 trailing
        '{10'h001, mkhdr(4'd1, 3'd2, 4'd4, 12'h000, 8'hAA), 32'h1234_5678, 4'd0, 4'd0, 2'd0}, // R3 header only
        '{10'h041, mkhdr(4'd3, 3'd5, 4'd8, 12'h000, 8'hBB), 32'h1234_5678, 4'd0, 4'd0, 2'd0}  // R3 top group, R4 alg
    };

    function automatic logic [31:0] kw(int v, int n);
        return 32'hC0DE_0000 | (v << 8) | n;
    endfunction

    task automatic run_vec(input int v);
        vec_t              t;
        logic [31:0]       w [24];
        int                n;
        int                total;
        logic [255:0]      kexp;
        logic [32*IVW-1:0] ivexp;
        logic              present;
        logic              rv0, rv1, e0, e1;
        logic [15:0]       plen, hlen;
        t     = VECS[v];
        n     = 0;
        kexp  = '0;
        ivexp = '0;
        w[n] = t.hdr; n = n + 1;
        if (t.flag[1]) begin w[n] = t.lenw; n = n + 1; end
        if (t.flag[3]) begin
            for (int m = 0; m < IVW; m++) begin
                w[n] = 32'h1A00_0000 | m; n = n + 1;
                ivexp[32*IVW-1-32*m -: 32] = 32'h1A00_0000 | m;
            end
        end
        for (int k = 0; k < 8; k++) begin
            present = (k < 4) ? t.flag[4] : (k < 6) ? t.flag[5] : t.flag[6];
            if (present) begin
                w[n] = kw(v, k); n = n + 1;
                kexp[255-32*k -: 32] = kw(v, k);
            end
        end
        for (int e = 0; e < int'(t.extra); e++) w[n+e] = 32'hDEAD_0000 | e;
        total = n + int'(t.extra) - int'(t.cut);
        plen  = t.flag[1] ? t.lenw[15:0]  : 16'h0;
        hlen  = t.flag[1] ? t.lenw[31:16] : 16'h0;

        @(negedge clk);
        desc_valid = 1'b1;
        desc_flag  = t.flag;
        @(negedge clk);
        desc_valid = 1'b0;
        for (int j = 0; j < total; j++) begin
            in_valid = 1'b1;
            in_data  = w[j];
            in_last  = (j == total - 1);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        rv0 = rec_valid;
        e0  = proto_err;
        @(negedge clk);
        rv1 = rec_valid;
        e1  = proto_err;

        if (t.outcome == 2'd0) begin
            chk(!rv0 && !e0 && rv1 && !e1, $sformatf("R11 v%0d record timing", v),
                {rv0, e0, rv1, e1}, 4'b0010);
            chk({rec_decrypt, rec_algo, rec_key_words, rec_proc_id} ==
                {t.hdr[31:28] == 4'd3, t.hdr[26:24], t.hdr[23:20], t.hdr[7:0]},
                $sformatf("R4 v%0d header fields", v),
                {rec_decrypt, rec_algo, rec_key_words, rec_proc_id},
                {t.hdr[31:28] == 4'd3, t.hdr[26:24], t.hdr[23:20], t.hdr[7:0]});
            chk({rec_hdr_len, rec_payload_len} == {hlen, plen}, $sformatf("R5 v%0d lengths", v),
                {rec_hdr_len, rec_payload_len}, {hlen, plen});
            chk(rec_key == kexp, $sformatf("R3 R6 R9 v%0d key", v), rec_key, kexp);
            chk(rec_iv == ivexp, $sformatf("R3 v%0d iv", v), rec_iv, ivexp);
            @(negedge clk);
            @(negedge clk);
            chk(rec_valid && !in_ready && !desc_ready && rec_key == kexp,
                $sformatf("R10 v%0d held", v), {rec_valid, in_ready, desc_ready}, 3'b100);
            rec_ready = 1'b1;
            @(negedge clk);
            rec_ready = 1'b0;
            chk(!rec_valid && desc_ready, $sformatf("R10 v%0d released", v),
                {rec_valid, desc_ready}, 2'b01);
        end else if (t.outcome == 2'd1) begin
            chk(!rv0 && !e0 && !rv1 && e1, $sformatf("R7 R11 v%0d bad header error", v),
                {rv0, e0, rv1, e1}, 4'b0001);
            @(negedge clk);
            chk(!proto_err && !rec_valid && desc_ready, $sformatf("R7 v%0d single pulse", v),
                {proto_err, rec_valid, desc_ready}, 3'b001);
        end else begin
            chk(!rv0 && e0 && !rv1 && !e1 && desc_ready, $sformatf("R8 v%0d short buffer", v),
                {rv0, e0, rv1, e1, desc_ready}, 5'b01001);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!rec_valid && !proto_err && !in_ready && desc_ready, "R1 reset state",
            {rec_valid, proto_err, in_ready, desc_ready}, 4'b0001);

        // R2: data-only descriptor consumes nothing
        desc_valid = 1'b1;
        desc_flag  = 10'h070;
        @(negedge clk);
        desc_valid = 1'b0;
        in_valid   = 1'b1;
        in_data    = 32'hBAD0_BAD0;
        in_last    = 1'b1;
        @(negedge clk);
        chk(desc_ready && !in_ready && !rec_valid && !proto_err, "R2 data descriptor ignored",
            {desc_ready, in_ready, rec_valid, proto_err}, 4'b1000);
        in_valid = 1'b0;
        in_last  = 1'b0;

        for (int v = 0; v < NV; v++) run_vec(v);

        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule